// File: doc/BRIEF.md
# Priority Interrupt Dispatch Unit

This block sits next to a processor's exception sequencer. Every cycle it looks at the pending interrupt level and decides whether that interrupt is taken. The decision uses the current status word, the interrupt-set and interrupt-enable masks, and a table that gives each priority level its own source mask. When the interrupt is taken, the block produces, one cycle later, everything the core needs to enter the handler: write strobes and data for the status word, the per-level PC and status save registers, the double-exception PC register and the exception-cause register, the new fetch address, and a code for the kind of entry.

Levels above 1 are dispatched directly. They save state into that level's own save registers, raise the interrupt-level field and jump to a per-level vector. Level 1 is not vectored on its own. It becomes a kernel, user or double exception, depending on the user-mode and exception-mode bits, and goes through the matching exception vector. Vectors can be rebased at run time through the vector-base input, or held at their build-time addresses.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is taken only when all three of these hold: the pending level is greater than the status level field ps[3:0], the pending level is at most NUM_LEVELS, and (the pending level's slice of the mask table AND the set mask AND the enable mask) is nonzero. Level L uses mask-table bits [(L-1)*NUM_IRQ +: NUM_IRQ].
- R2: For a taken level L of 2 or more, epc_we_o bit L-1 and eps_we_o bit L-2 are the only save strobes raised. save_pc_o carries the PC, and eps_wdata_o carries the status word as sampled.
- R3: For a taken level L of 2 or more, kind_o is 1. The new status word keeps ps[31:5], sets bit 4 and writes L into [3:0]. The new PC is the base plus 0x180 + (L-2)*0x40.
- R4: For a taken level-1 interrupt, cause_we_o is raised and cause_o is 4. For any other outcome cause_we_o stays low.
- R5: For a taken level-1 interrupt with ps[4] clear, epc_we_o bit 0 is raised. With ps[5] set, kind_o is 3 (user) and the PC is the base plus 0x340. With ps[5] clear, kind_o is 2 (kernel) and the PC is the base plus 0x300.
- R6: For a taken level-1 interrupt with ps[4] set, kind_o is 4 (double) and the PC is the base plus 0x3C0. The PC is saved through depc_we_o when HAS_DEPC is 1, and through epc_we_o bit 0 otherwise.
- R7: Every taken interrupt writes a status word with the exception-mode bit 4 set. Level 1 writes ps OR 0x10.
- R8: With RELOC_EN=1 the base is vecbase_i. With RELOC_EN=0 the base is DEF_VECBASE (default 0x4000_0000).
- R9: During reset taken_o is 0, kind_o is 0 and all strobes are 0. next_pc_o is RESET_VEC (default 0x5000_0000). ps_wdata_o is 0x1F when HAS_INT is 1 and 0x10 otherwise.
- R10: Outputs appear on the clock edge after the inputs are sampled, and taken_o is high for that single cycle. A cycle with no take drives taken_o, kind_o and all strobes to 0 and holds the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_lvl_i | input | 4 | Pending interrupt level, 0 for none |
| int_set_i | input | NUM_IRQ | Interrupt-set mask |
| int_en_i | input | NUM_IRQ | Interrupt-enable mask |
| lvl_mask_i | input | NUM_LEVELS*NUM_IRQ | Per-level source mask table |
| ps_i | input | 32 | Current status word |
| pc_i | input | 32 | Current PC |
| vecbase_i | input | 32 | Vector base register |
| taken_o | output | 1 | Interrupt taken pulse |
| kind_o | output | 3 | Entry kind: 0 none, 1 level, 2 kernel, 3 user, 4 double |
| next_pc_o | output | 32 | Next fetch address |
| ps_we_o | output | 1 | Status word write strobe |
| ps_wdata_o | output | 32 | New status word |
| save_pc_o | output | 32 | PC value for the save registers |
| epc_we_o | output | NUM_LEVELS | PC save strobe per level (bit L-1) |
| depc_we_o | output | 1 | Double-exception PC strobe |
| eps_we_o | output | NUM_LEVELS-1 | Status save strobe per level (bit L-2) |
| eps_wdata_o | output | 32 | Status value for the save registers |
| cause_we_o | output | 1 | Exception-cause write strobe |
| cause_o | output | 6 | Exception-cause value |

## Verification
The assertions assume the inputs are stable and known at each sampling edge, and that pend_lvl_i never exceeds 15. They relate each registered output to the inputs of the previous cycle only. The stimulus changes inputs on the falling edge and presents each case for exactly one cycle. It returns the pending level to a non-qualifying value between cases, so each taken pulse can be traced to one input set. Mask-table slices in the bench are disjoint, so a set bit qualifies at most one level.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int PS_LVL_W  = 4;
  localparam int PS_EXCM_B = 4;
  localparam int PS_UM_B   = 5;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_LEVEL  = 3'd1,
    KIND_KERNEL = 3'd2,
    KIND_USER   = 3'd3,
    KIND_DOUBLE = 3'd4
  } disp_kind_e;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int unsigned NUM_LEVELS = 6,
  parameter int unsigned NUM_IRQ    = 32
) (
  input  logic [3:0]                    pend_lvl_i,
  input  logic [3:0]                    cur_lvl_i,
  input  logic [NUM_IRQ-1:0]            int_set_i,
  input  logic [NUM_IRQ-1:0]            int_en_i,
  input  logic [NUM_LEVELS*NUM_IRQ-1:0] lvl_mask_i,
  output logic                          take_o
);
  logic [NUM_LEVELS:1] lvl_hit;
  logic                sel_hit;

  for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
    assign lvl_hit[l] = |(lvl_mask_i[(l-1)*NUM_IRQ +: NUM_IRQ] & int_set_i & int_en_i);
  end

  // level 0 and levels beyond NUM_LEVELS select nothing
  always_comb begin
    sel_hit = 1'b0;
    for (int l = 1; l <= NUM_LEVELS; l++) begin
      if (pend_lvl_i == 4'(l)) sel_hit = lvl_hit[l];
    end
  end

  assign take_o = sel_hit && (pend_lvl_i > cur_lvl_i);
endmodule

// File: rtl/irq_state_upd.sv
module irq_state_upd
  import irq_dispatch_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 6,
  parameter bit          HAS_DEPC   = 1'b1
) (
  input  logic                  take_i,
  input  logic [3:0]            lvl_i,
  input  logic [31:0]           ps_i,
  output disp_kind_e            kind_o,
  output logic [31:0]           ps_new_o,
  output logic [NUM_LEVELS-1:0] epc_we_o,
  output logic [NUM_LEVELS-2:0] eps_we_o,
  output logic                  depc_we_o,
  output logic                  cause_we_o
);
  logic [NUM_LEVELS-1:0] epc_lvl;
  logic [NUM_LEVELS-2:0] eps_lvl;

  always_comb begin
    epc_lvl = '0;
    eps_lvl = '0;
    for (int l = 1; l <= NUM_LEVELS; l++) begin
      if (lvl_i == 4'(l)) epc_lvl[l-1] = 1'b1;
    end
    for (int l = 2; l <= NUM_LEVELS; l++) begin
      if (lvl_i == 4'(l)) eps_lvl[l-2] = 1'b1;
    end
  end

  always_comb begin
    kind_o     = KIND_NONE;
    ps_new_o   = ps_i;
    epc_we_o   = '0;
    eps_we_o   = '0;
    depc_we_o  = 1'b0;
    cause_we_o = 1'b0;
    if (take_i) begin
      if (lvl_i > 4'd1) begin
        kind_o   = KIND_LEVEL;
        ps_new_o = {ps_i[31:PS_EXCM_B+1], 1'b1, lvl_i};
        epc_we_o = epc_lvl;
        eps_we_o = eps_lvl;
      end else begin
        cause_we_o            = 1'b1;
        ps_new_o[PS_EXCM_B]   = 1'b1;
        if (ps_i[PS_EXCM_B]) begin
          kind_o = KIND_DOUBLE;
          if (HAS_DEPC) depc_we_o   = 1'b1;
          else          epc_we_o[0] = 1'b1;
        end else begin
          kind_o      = ps_i[PS_UM_B] ? KIND_USER : KIND_KERNEL;
          epc_we_o[0] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_dispatch_pkg::*;
#(
  parameter bit          RELOC_EN    = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [31:0] OFS_LVL2    = 32'h0000_0180,
  parameter logic [31:0] VEC_STRIDE  = 32'h0000_0040,
  parameter logic [31:0] OFS_KERNEL  = 32'h0000_0300,
  parameter logic [31:0] OFS_USER    = 32'h0000_0340,
  parameter logic [31:0] OFS_DOUBLE  = 32'h0000_03C0
) (
  input  logic [31:0] vecbase_i,
  input  logic [3:0]  lvl_i,
  input  disp_kind_e  kind_i,
  output logic [31:0] vec_o
);
  logic [31:0] cfg_vec;
  logic [31:0] ofs;

  always_comb begin
    unique case (kind_i)
      KIND_LEVEL:  ofs = OFS_LVL2 + (32'(lvl_i) - 32'd2) * VEC_STRIDE;
      KIND_USER:   ofs = OFS_USER;
      KIND_DOUBLE: ofs = OFS_DOUBLE;
      default:     ofs = OFS_KERNEL;
    endcase
  end

  assign cfg_vec = DEF_VECBASE + ofs;

  if (RELOC_EN) begin : g_reloc
    assign vec_o = cfg_vec - DEF_VECBASE + vecbase_i;
  end else begin : g_fixed
    assign vec_o = cfg_vec;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int unsigned NUM_LEVELS  = 6,
  parameter int unsigned NUM_IRQ     = 32,
  parameter bit          HAS_DEPC    = 1'b1,
  parameter bit          RELOC_EN    = 1'b1,
  parameter bit          HAS_INT     = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [31:0] RESET_VEC   = 32'h5000_0000,
  parameter logic [5:0]  L1_CAUSE    = 6'd4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [3:0]                    pend_lvl_i,
  input  logic [NUM_IRQ-1:0]            int_set_i,
  input  logic [NUM_IRQ-1:0]            int_en_i,
  input  logic [NUM_LEVELS*NUM_IRQ-1:0] lvl_mask_i,
  input  logic [31:0]                   ps_i,
  input  logic [31:0]                   pc_i,
  input  logic [31:0]                   vecbase_i,
  output logic                          taken_o,
  output logic [2:0]                    kind_o,
  output logic [31:0]                   next_pc_o,
  output logic                          ps_we_o,
  output logic [31:0]                   ps_wdata_o,
  output logic [31:0]                   save_pc_o,
  output logic [NUM_LEVELS-1:0]         epc_we_o,
  output logic                          depc_we_o,
  output logic [NUM_LEVELS-2:0]         eps_we_o,
  output logic [31:0]                   eps_wdata_o,
  output logic                          cause_we_o,
  output logic [5:0]                    cause_o
);
  localparam logic [31:0] RST_PS = HAS_INT ? 32'h0000_001F : 32'h0000_0010;

  logic                  take;
  disp_kind_e            kind_d;
  logic [31:0]           ps_new;
  logic [31:0]           vec;
  logic [NUM_LEVELS-1:0] epc_we_d;
  logic [NUM_LEVELS-2:0] eps_we_d;
  logic                  depc_we_d;
  logic                  cause_we_d;

  irq_qualify #(.NUM_LEVELS(NUM_LEVELS), .NUM_IRQ(NUM_IRQ)) u_qual (
    .pend_lvl_i (pend_lvl_i),
    .cur_lvl_i  (ps_i[PS_LVL_W-1:0]),
    .int_set_i  (int_set_i),
    .int_en_i   (int_en_i),
    .lvl_mask_i (lvl_mask_i),
    .take_o     (take)
  );

  irq_state_upd #(.NUM_LEVELS(NUM_LEVELS), .HAS_DEPC(HAS_DEPC)) u_upd (
    .take_i     (take),
    .lvl_i      (pend_lvl_i),
    .ps_i       (ps_i),
    .kind_o     (kind_d),
    .ps_new_o   (ps_new),
    .epc_we_o   (epc_we_d),
    .eps_we_o   (eps_we_d),
    .depc_we_o  (depc_we_d),
    .cause_we_o (cause_we_d)
  );

  irq_vec_gen #(.RELOC_EN(RELOC_EN), .DEF_VECBASE(DEF_VECBASE)) u_vec (
    .vecbase_i (vecbase_i),
    .lvl_i     (pend_lvl_i),
    .kind_i    (kind_d),
    .vec_o     (vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o     <= 1'b0;
      kind_o      <= KIND_NONE;
      ps_we_o     <= 1'b0;
      epc_we_o    <= '0;
      eps_we_o    <= '0;
      depc_we_o   <= 1'b0;
      cause_we_o  <= 1'b0;
      next_pc_o   <= RESET_VEC;
      ps_wdata_o  <= RST_PS;
      save_pc_o   <= '0;
      eps_wdata_o <= '0;
      cause_o     <= '0;
    end else begin
      taken_o    <= take;
      kind_o     <= kind_d;
      ps_we_o    <= take;
      epc_we_o   <= epc_we_d;
      eps_we_o   <= eps_we_d;
      depc_we_o  <= depc_we_d;
      cause_we_o <= cause_we_d;
      if (take) begin
        next_pc_o   <= vec;
        ps_wdata_o  <= ps_new;
        save_pc_o   <= pc_i;
        eps_wdata_o <= ps_i;
      end
      if (cause_we_d) cause_o <= L1_CAUSE;
    end
  end

  AST_TAKE_ABOVE_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> $past(pend_lvl_i) > $past(ps_i[3:0])); // R1
  AST_TAKE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> 32'($past(pend_lvl_i)) <= NUM_LEVELS); // R1
  AST_SAVE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({epc_we_o, depc_we_o})); // R2
  AST_SAVE_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> save_pc_o == $past(pc_i)); // R2
  AST_LVL_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == KIND_LEVEL) |-> ps_wdata_o[3:0] == $past(pend_lvl_i)); // R3
  AST_CAUSE_L1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_we_o |-> (kind_o inside {KIND_KERNEL, KIND_USER, KIND_DOUBLE})); // R4
  AST_EXCM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_we_o |-> ps_wdata_o[PS_EXCM_B]); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> (epc_we_o == '0 && eps_we_o == '0 && !depc_we_o && !cause_we_o)); // R10
endmodule

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  localparam int NL = 6;
  localparam int NI = 32;

  typedef struct packed {
    logic [3:0]  lvl;
    logic [31:0] ps;
    logic [31:0] set;
    logic [31:0] en;
    logic [31:0] pc;
    logic        tk;
    logic [2:0]  kind;
    logic [31:0] npc;
    logic [31:0] nps;
    logic [5:0]  epc;
    logic [4:0]  eps;
    logic        depc;
  } vec_t;

  // vecbase_i = 0x6000_0000, level L owns set bits [4L-1:4L-4]
  localparam vec_t VECS [12] = '{
    '{4'd3, 32'h00, 32'h100, 32'hFFFF_FFFF, 32'h1000, 1'b1, 3'd1, 32'h6000_01C0, 32'h13, 6'b000100, 5'b00010, 1'b0}, // R3
    '{4'd3, 32'h03, 32'h100, 32'hFFFF_FFFF, 32'h1100, 1'b0, 3'd0, 32'h0, 32'h0, 6'b0, 5'b0, 1'b0},                     // R1 equal level
    '{4'd3, 32'h02, 32'h100, 32'h0,         32'h1200, 1'b0, 3'd0, 32'h0, 32'h0, 6'b0, 5'b0, 1'b0},                     // R1 disabled
    '{4'd3, 32'h00, 32'h001, 32'hFFFF_FFFF, 32'h1300, 1'b0, 3'd0, 32'h0, 32'h0, 6'b0, 5'b0, 1'b0},                     // R1 wrong level mask
    '{4'd7, 32'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1400, 1'b0, 3'd0, 32'h0, 32'h0, 6'b0, 5'b0, 1'b0},               // R1 beyond NUM_LEVELS
    '{4'd6, 32'h25, 32'h0010_0000, 32'hFFFF_FFFF, 32'h2000, 1'b1, 3'd1, 32'h6000_0280, 32'h36, 6'b100000, 5'b10000, 1'b0}, // R2
    '{4'd1, 32'h00, 32'h1, 32'hFFFF_FFFF, 32'h3000, 1'b1, 3'd2, 32'h6000_0300, 32'h10, 6'b000001, 5'b0, 1'b0},         // R5 kernel
    '{4'd1, 32'h20, 32'h2, 32'hFFFF_FFFF, 32'h3004, 1'b1, 3'd3, 32'h6000_0340, 32'h30, 6'b000001, 5'b0, 1'b0},         // R5 user
    '{4'd1, 32'h10, 32'h4, 32'hFFFF_FFFF, 32'h3008, 1'b1, 3'd4, 32'h6000_03C0, 32'h10, 6'b0, 5'b0, 1'b1},              // R6 double
    '{4'd2, 32'h31, 32'h10, 32'hFFFF_FFFF, 32'h4000, 1'b1, 3'd1, 32'h6000_0180, 32'h32, 6'b000010, 5'b00001, 1'b0},    // R7
    '{4'd0, 32'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h4100, 1'b0, 3'd0, 32'h0, 32'h0, 6'b0, 5'b0, 1'b0},               // R10 idle
    '{4'd1, 32'h21, 32'h1, 32'hFFFF_FFFF, 32'h4200, 1'b0, 3'd0, 32'h0, 32'h0, 6'b0, 5'b0, 1'b0}                        // R1 level1 masked
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      pend_lvl = '0;
  logic [NI-1:0]   int_set = '0;
  logic [NI-1:0]   int_en = '0;
  logic [NL*NI-1:0] lvl_mask = '0;
  logic [31:0]     ps = '0;
  logic [31:0]     pc = '0;
  logic [31:0]     vecbase = 32'h6000_0000;

  logic        taken_a, taken_b, ps_we_a, ps_we_b, depc_a, depc_b, cwe_a, cwe_b;
  logic [2:0]  kind_a, kind_b;
  logic [31:0] npc_a, npc_b, psw_a, psw_b, spc_a, spc_b, epsw_a, epsw_b;
  logic [NL-1:0] epc_a, epc_b;
  logic [NL-2:0] eps_a, eps_b;
  logic [5:0]  cause_a, cause_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] last_npc = 32'h5000_0000;
  logic [31:0] last_ps = 32'h1F;

  always #4 clk = ~clk;

  irq_dispatch #(.NUM_LEVELS(NL), .NUM_IRQ(NI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pend_lvl_i(pend_lvl), .int_set_i(int_set), .int_en_i(int_en),
    .lvl_mask_i(lvl_mask), .ps_i(ps), .pc_i(pc), .vecbase_i(vecbase),
    .taken_o(taken_a), .kind_o(kind_a), .next_pc_o(npc_a), .ps_we_o(ps_we_a), .ps_wdata_o(psw_a),
    .save_pc_o(spc_a), .epc_we_o(epc_a), .depc_we_o(depc_a), .eps_we_o(eps_a), .eps_wdata_o(epsw_a),
    .cause_we_o(cwe_a), .cause_o(cause_a)
  );

  irq_dispatch #(.NUM_LEVELS(NL), .NUM_IRQ(NI), .HAS_DEPC(1'b0), .RELOC_EN(1'b0), .HAS_INT(1'b0)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .pend_lvl_i(pend_lvl), .int_set_i(int_set), .int_en_i(int_en),
    .lvl_mask_i(lvl_mask), .ps_i(ps), .pc_i(pc), .vecbase_i(vecbase),
    .taken_o(taken_b), .kind_o(kind_b), .next_pc_o(npc_b), .ps_we_o(ps_we_b), .ps_wdata_o(psw_b),
    .save_pc_o(spc_b), .epc_we_o(epc_b), .depc_we_o(depc_b), .eps_we_o(eps_b), .eps_wdata_o(epsw_b),
    .cause_we_o(cwe_b), .cause_o(cause_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic drive(input logic [3:0] l, input logic [31:0] p, input logic [31:0] s,
                       input logic [31:0] e, input logic [31:0] c);
    pend_lvl = l; ps = p; int_set = s; int_en = e; pc = c;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int l = 1; l <= NL; l++) lvl_mask[(l-1)*NI +: NI] = 32'hF << (4*(l-1));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 taken", 32'(taken_a), 32'h0);
    chk("R9 kind", 32'(kind_a), 32'h0);
    chk("R9 strobes", 32'({epc_a, eps_a, depc_a, cwe_a, ps_we_a}), 32'h0);
    chk("R9 next_pc", npc_a, 32'h5000_0000);
    chk("R9 ps int", psw_a, 32'h1F);
    chk("R9 ps noint", psw_b, 32'h10);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      drive(VECS[i].lvl, VECS[i].ps, VECS[i].set, VECS[i].en, VECS[i].pc);
      @(negedge clk);
      chk("R1 taken", 32'(taken_a), 32'(VECS[i].tk));
      chk("R10 kind", 32'(kind_a), 32'(VECS[i].kind));
      chk("R2 epc_we", 32'(epc_a), 32'(VECS[i].epc));
      chk("R2 eps_we", 32'(eps_a), 32'(VECS[i].eps));
      chk("R6 depc_we", 32'(depc_a), 32'(VECS[i].depc));
      chk("R4 cause_we", 32'(cwe_a), 32'(VECS[i].kind >= 3'd2));
      if (VECS[i].tk) begin
        chk("R3 next_pc", npc_a, VECS[i].npc);
        chk("R7 ps_wdata", psw_a, VECS[i].nps);
        chk("R2 save_pc", spc_a, VECS[i].pc);
        chk("R2 eps_wdata", epsw_a, VECS[i].ps);
        if (VECS[i].kind >= 3'd2) chk("R4 cause", 32'(cause_a), 32'd4);
        last_npc = VECS[i].npc;
        last_ps = VECS[i].nps;
      end else begin
        chk("R10 hold pc", npc_a, last_npc);
        chk("R10 hold ps", psw_a, last_ps);
      end
      drive(4'd0, 32'h0, 32'h0, 32'h0, 32'h0);
      @(negedge clk);
      chk("R10 pulse", 32'(taken_a), 32'h0);
    end

    // R6 double without DEPC, R8 fixed base
    drive(4'd1, 32'h10, 32'h1, 32'hFFFF_FFFF, 32'h5000);
    @(negedge clk);
    chk("R6 kind_b", 32'(kind_b), 32'd4);
    chk("R6 epc_b", 32'(epc_b), 32'h1);
    chk("R6 depc_b", 32'(depc_b), 32'h0);
    chk("R8 dbl vec_b", npc_b, 32'h4000_03C0);
    chk("R8 dbl vec_a", npc_a, 32'h6000_03C0);
    drive(4'd2, 32'h0, 32'h10, 32'hFFFF_FFFF, 32'h5100);
    @(negedge clk);
    chk("R8 lvl2 vec_b", npc_b, 32'h4000_0180);
    chk("R3 lvl2 ps_b", psw_b, 32'h12);
    drive(4'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule